// File: doc/BRIEF.md
# Serial Flash Status Register Guard

This block keeps the 24-bit status/control word of a serial NOR flash model and decides, command by command, whether a state-changing request may proceed. It sits behind an already-decoded command path: each request arrives as a one-cycle strobe (latch set, latch clear, status write with a 24-bit data word, page program, sector erase, block erase, full-array erase). One cycle later the block raises either an accept or a reject pulse. An accepted write, program or erase holds the in-progress bit for a number of cycles taken from the `op_cycles` input. A `pwr_cycle` pulse stands for a power-down/power-up sequence.

Writes are governed by the write-enable latch and by a two-bit lock field. The lock field has a free state, a lock that a power cycle releases, and a permanent lock. Full-array erase is allowed only when the low three protection bits and the complement bit agree: all clear with the complement bit clear, or all set with it set. The quad-enable bit is fixed at 1.

Every interface is a plain strobe or level. There is no back-pressure. A request that cannot be served is answered with a reject pulse and is not queued, so the caller reads `busy` or the reject flag and retries.

Top module: `sreg_guard`

## Requirements
- R1: After reset `status` equals 0x000200, `busy` is 0, and neither `cmd_accept` nor `cmd_reject` is set.
- R2: Every strobe is answered exactly one cycle later by a one-cycle `cmd_accept` or a one-cycle `cmd_reject`, never both. Latch-set (`cmd_wren`) sets bit 1 (latch) and latch-clear (`cmd_wrdi`) clears it, both when idle.
- R3: Status write, program, sector, block and full erase are rejected while bit 1 is 0. A rejected one of these clears bit 1.
- R4: An accepted status write loads bits 2–6 (protection bits, bit 2 lowest), 7–8 (lock field, bit 8 high), 14 (complement) and 21–22 from the data word. Bits 0, 1, 10, 15 and reserved bits 16–20 and 23 ignore the data. Bit 9 always reads 1 and reserved bits read 0.
- R5: Bits 11–13 can be set by a status write but never cleared.
- R6: With lock field 2'b10, status writes are rejected. A power cycle changes the field to 2'b00 and keeps the other stored bits.
- R7: With lock field 2'b11, status writes are rejected and a power cycle keeps the field. Field 2'b01 behaves like 2'b00.
- R8: Full erase (with bit 1 set) is accepted only if bits 4:2 = 000 with bit 14 = 0, or bits 4:2 = 111 with bit 14 = 1.
- R9: An accepted write, program or erase sets bit 0 and `busy` for `op_cycles` cycles (one cycle when `op_cycles` is 0). When the operation ends, bits 0 and 1 clear together.
- R10: Any strobe that arrives while `busy` is 1 is rejected and changes no state.
- R11: Two or more strobes in one cycle are all rejected as one request and change no state.
- R12: `pwr_cycle` ends any operation and clears bits 0 and 1 at the next edge. Strobes in the same cycle are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the register to defaults |
| pwr_cycle | input | 1 | One-cycle power-cycle event |
| op_cycles | input | CNT_W | Busy length of an operation, in cycles |
| cmd_wren | input | 1 | Write-enable latch set strobe |
| cmd_wrdi | input | 1 | Write-enable latch clear strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 24 | Data word for status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Block erase strobe |
| cmd_ce | input | 1 | Full-array erase strobe |
| status | output | 24 | Current status/control word |
| cmd_accept | output | 1 | Request accepted, one cycle after the strobe |
| cmd_reject | output | 1 | Request refused, one cycle after the strobe |
| busy | output | 1 | Operation in progress (mirrors bit 0) |

## Verification
A stale latch shows up one cycle after the next write-class strobe, as an accept where a reject belongs, or the reverse. A wrong lock field shows up at the next status write or power cycle, as a refused or an allowed load that the bench can see on `status` straight away. A miscounted busy timer changes how many cycles `busy` stays high, and it also moves the cycle in which bit 1 falls. A wrong protection decode only shows when a full erase is issued, and then in the accept/reject flag of the following cycle.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  localparam int SR_W  = 24;
  localparam int NCMD  = 7;

  // strobe positions inside the command vector
  localparam int C_WREN = 0;
  localparam int C_WRDI = 1;
  localparam int C_WRSR = 2;
  localparam int C_PP   = 3;
  localparam int C_SE   = 4;
  localparam int C_BE   = 5;
  localparam int C_CE   = 6;

  localparam int B_WIP  = 0;
  localparam int B_WEL  = 1;
  localparam int B_QE   = 9;
  localparam int B_CMP  = 14;
  localparam int B_LK0  = 7;
  localparam int B_LK1  = 8;

  // freely rewritable bits: protect[6:2], lock[8:7], complement[14], drive[22:21]
  localparam logic [SR_W-1:0] WR_MASK  = 24'h6041FC;
  // set-only bits [13:11]
  localparam logic [SR_W-1:0] LB_MASK  = 24'h003800;
  localparam logic [SR_W-1:0] QE_BIT   = 24'h000200;

  typedef struct packed {
    logic acc;
    logic rej;
    logic wel_set;
    logic wel_clr;
    logic sr_load;
    logic op_start;
  } verdict_t;

  function automatic logic full_erase_ok(input logic [2:0] prot_lo, input logic cmp);
    return ((prot_lo == 3'b000) && !cmp) || ((prot_lo == 3'b111) && cmp);
  endfunction
endpackage

// File: rtl/sreg_cmd_judge.sv
`timescale 1ns/1ps
module sreg_cmd_judge
  import sreg_pkg::*;
(
  input  logic [NCMD-1:0] cmd,
  input  logic            busy,
  input  logic            pwr_cycle,
  input  logic            wel,
  input  logic [1:0]      lock,
  input  logic [2:0]      prot_lo,
  input  logic            cmp,
  output verdict_t        v
);
  logic ok;

  always_comb begin
    v  = '0;
    ok = 1'b0;
    if (cmd != '0) begin
      if (pwr_cycle || busy || ($countones(cmd) != 1)) begin
        v.rej = 1'b1;
      end else if (cmd[C_WREN]) begin
        v.acc     = 1'b1;
        v.wel_set = 1'b1;
      end else if (cmd[C_WRDI]) begin
        v.acc     = 1'b1;
        v.wel_clr = 1'b1;
      end else begin
        ok = wel;
        if (cmd[C_WRSR]) ok = ok && !lock[1];
        if (cmd[C_CE])   ok = ok && full_erase_ok(prot_lo, cmp);
        if (ok) begin
          v.acc      = 1'b1;
          v.op_start = 1'b1;
          v.sr_load  = cmd[C_WRSR];
        end else begin
          v.rej     = 1'b1;
          v.wel_clr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sreg_op_timer.sv
`timescale 1ns/1ps
module sreg_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (abort)         cnt_q <= '0;
    else if (start)         cnt_q <= (len == '0) ? ONE : len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);
endmodule

// File: rtl/sreg_store.sv
`timescale 1ns/1ps
module sreg_store
  import sreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_cycle,
  input  logic            op_done,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            sr_load,
  input  logic [SR_W-1:0] wr_data,
  output logic [SR_W-1:0] nv_q,
  output logic            wel_q
);
  logic [SR_W-1:0] nv_d;

  always_comb begin
    nv_d = nv_q;
    if (pwr_cycle) begin
      if (nv_q[B_LK1] && !nv_q[B_LK0]) begin
        nv_d[B_LK1] = 1'b0;
        nv_d[B_LK0] = 1'b0;
      end
    end else if (sr_load) begin
      nv_d = (wr_data & (WR_MASK | LB_MASK)) | (nv_q & LB_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
    end else begin
      nv_q <= nv_d;
      if (pwr_cycle || op_done) wel_q <= 1'b0;
      else if (wel_set)         wel_q <= 1'b1;
      else if (wel_clr)         wel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sreg_guard.sv
`timescale 1ns/1ps
module sreg_guard
  import sreg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_cycle,
  input  logic [CNT_W-1:0] op_cycles,
  input  logic             cmd_wren,
  input  logic             cmd_wrdi,
  input  logic             cmd_wrsr,
  input  logic [SR_W-1:0]  wrsr_data,
  input  logic             cmd_pp,
  input  logic             cmd_se,
  input  logic             cmd_be,
  input  logic             cmd_ce,
  output logic [SR_W-1:0]  status,
  output logic             cmd_accept,
  output logic             cmd_reject,
  output logic             busy
);
  logic [NCMD-1:0] cmd;
  verdict_t        v;
  logic [SR_W-1:0] nv_q;
  logic            wel_q;
  logic            op_done;

  assign cmd = {cmd_ce, cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren};

  sreg_cmd_judge u_judge (
    .cmd       (cmd),
    .busy      (busy),
    .pwr_cycle (pwr_cycle),
    .wel       (wel_q),
    .lock      (nv_q[B_LK1:B_LK0]),
    .prot_lo   (nv_q[4:2]),
    .cmp       (nv_q[B_CMP]),
    .v         (v)
  );

  sreg_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (v.op_start),
    .abort (pwr_cycle),
    .len   (op_cycles),
    .busy  (busy),
    .done  (op_done)
  );

  sreg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_cycle (pwr_cycle),
    .op_done   (op_done),
    .wel_set   (v.wel_set),
    .wel_clr   (v.wel_clr),
    .sr_load   (v.sr_load),
    .wr_data   (wrsr_data),
    .nv_q      (nv_q),
    .wel_q     (wel_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= v.acc;
      cmd_reject <= v.rej;
    end
  end

  assign status = nv_q | QE_BIT | {{(SR_W-2){1'b0}}, wel_q, busy};
endmodule

// File: rtl/sreg_guard_chk.sv
`timescale 1ns/1ps
module sreg_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_cycle,
  input logic        cmd_wren,
  input logic        cmd_wrdi,
  input logic        cmd_wrsr,
  input logic        cmd_pp,
  input logic        cmd_se,
  input logic        cmd_be,
  input logic        cmd_ce,
  input logic [23:0] status,
  input logic        cmd_accept,
  input logic        cmd_reject,
  input logic        busy
);
  logic [6:0] strobes;
  logic       single;
  logic       wclass;
  assign strobes = {cmd_ce, cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren};
  assign single  = ($countones(strobes) == 1);
  assign wclass  = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));

  p_latch_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (single && wclass && !status[1]) |=> cmd_reject);

  p_fixed_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[9] && ((status & 24'h9F8400) == 24'h000000));

  p_setonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[13:11] != 3'b000) |=> ((status[13:11] & $past(status[13:11])) == $past(status[13:11])));

  p_soft_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status[8] && !status[7]) |=> cmd_reject);

  p_hard_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[8:7] == 2'b11) |=> (status[8:7] == 2'b11));

  p_full_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (single && cmd_ce && !busy && !pwr_cycle && status[1] &&
     !(((status[4:2] == 3'b000) && !status[14]) || ((status[4:2] == 3'b111) && status[14])))
    |=> cmd_reject);

  p_wip_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == status[0]);

  p_busy_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (strobes != 7'd0)) |=> cmd_reject);

  p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobes) > 1) |=> (cmd_reject && $stable(status[8:2])));

  p_power_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (!busy && !status[1]));
endmodule

bind sreg_guard sreg_guard_chk u_chk (.*);

// File: tb/test_sreg_guard.sv
`timescale 1ns/1ps
module test_sreg_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_cycle = 1'b0;
  logic [7:0]  op_cycles = 8'd3;
  logic [6:0]  cmd_v = 7'd0;
  logic [23:0] wrsr_data = 24'd0;
  logic [23:0] status;
  logic        cmd_accept, cmd_reject, busy;

  int n_checks = 0;
  int n_fail = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  sreg_guard #(.CNT_W(8)) i_sreg_guard (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .op_cycles(op_cycles),
    .cmd_wren(cmd_v[0]), .cmd_wrdi(cmd_v[1]), .cmd_wrsr(cmd_v[2]),
    .wrsr_data(wrsr_data), .cmd_pp(cmd_v[3]), .cmd_se(cmd_v[4]),
    .cmd_be(cmd_v[5]), .cmd_ce(cmd_v[6]),
    .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .busy(busy)
  );

  // strobe codes: 01 latch set, 02 latch clear, 04 status write, 08 program,
  // 10 sector erase, 20 block erase, 40 full erase
  // row: {req number, strobes, data, expect accept, expect status after idle}
  localparam int NV = 39;
  localparam logic [63:0] VEC [NV] = '{
    {8'd3, 7'h04, 24'h000000, 1'b0, 24'h000200},  // R3 write without latch
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000202},  // R2
    {8'd4, 7'h04, 24'h60407C, 1'b1, 24'h60427C},  // R4 load protect, cmp, drive
    {8'd3, 7'h40, 24'h000000, 1'b0, 24'h60427C},  // R3 erase without latch
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h60427E},  // R2
    {8'd8, 7'h40, 24'h000000, 1'b1, 24'h60427C},  // R8 111 with cmp=1
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h60427E},  // R2
    {8'd4, 7'h04, 24'h000000, 1'b1, 24'h000200},  // R4
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000202},  // R2
    {8'd8, 7'h40, 24'h000000, 1'b1, 24'h000200},  // R8 000 with cmp=0
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000202},  // R2
    {8'd4, 7'h04, 24'h00000C, 1'b1, 24'h00020C},  // R4
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd8, 7'h40, 24'h000000, 1'b0, 24'h00020C},  // R8 011 refused, latch drops
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd9, 7'h08, 24'h000000, 1'b1, 24'h00020C},  // R9 program
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd9, 7'h10, 24'h000000, 1'b1, 24'h00020C},  // R9 sector erase
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd9, 7'h20, 24'h000000, 1'b1, 24'h00020C},  // R9 block erase
    {8'd2, 7'h02, 24'h000000, 1'b1, 24'h00020C},  // R2
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd2, 7'h02, 24'h000000, 1'b1, 24'h00020C},  // R2
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h00020E},  // R2
    {8'd5, 7'h04, 24'h004800, 1'b1, 24'h004A00},  // R5 set bit 11
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h004A02},  // R2
    {8'd5, 7'h04, 24'h000000, 1'b1, 24'h000A00},  // R5 bit 11 stays
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A02},  // R2
    {8'd4, 7'h04, 24'h818603, 1'b1, 24'h000A00},  // R4 fixed bits ignore data
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A02},  // R2
    {8'd7, 7'h04, 24'h000080, 1'b1, 24'h000A80},  // R7 field 01
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A82},  // R2
    {8'd7, 7'h04, 24'h000000, 1'b1, 24'h000A00},  // R7 01 acts as free
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A02},  // R2
    {8'd4, 7'h04, 24'h00001C, 1'b1, 24'h000A1C},  // R4
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A1E},  // R2
    {8'd8, 7'h40, 24'h000000, 1'b0, 24'h000A1C},  // R8 111 with cmp=0
    {8'd2, 7'h01, 24'h000000, 1'b1, 24'h000A1E},  // R2
    {8'd4, 7'h04, 24'h000000, 1'b1, 24'h000A00}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [6:0] m, input logic [23:0] d,
                       output logic acc, output logic rej);
    @(negedge clk);
    cmd_v = m;
    wrsr_data = d;
    @(negedge clk);
    acc = cmd_accept;
    rej = cmd_reject;
    cmd_v = 7'd0;
    wrsr_data = 24'd0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 300 && busy; k++) @(negedge clk);
  endtask

  task automatic pulse_power();
    @(negedge clk);
    pwr_cycle = 1'b1;
    @(negedge clk);
    pwr_cycle = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic a, r;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", {8'd0, status}, 32'h000200);
    check("R1 flags", {29'd0, busy, cmd_accept, cmd_reject}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", {8'd0, status}, 32'h000200);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][55:49], VEC[i][48:25], a, r);
      check($sformatf("R%0d row %0d answer", VEC[i][63:56], i), {30'd0, a, r},
            {30'd0, VEC[i][24], ~VEC[i][24]});
      wait_idle();
      check($sformatf("R%0d row %0d status", VEC[i][63:56], i), {8'd0, status},
            {8'd0, VEC[i][23:0]});
    end

    // R9 busy length 5, latch held during the operation
    op_cycles = 8'd5;
    issue(7'h01, 24'd0, a, r);
    issue(7'h08, 24'd0, a, r);
    check("R9 latch during op", {31'd0, status[1]}, 32'd1);
    count_busy(n);
    check("R9 busy length 5", n, 5);
    check("R9 end clears bits 1:0", {30'd0, status[1:0]}, 32'd0);

    // R9 zero length treated as one cycle
    op_cycles = 8'd0;
    issue(7'h01, 24'd0, a, r);
    issue(7'h10, 24'd0, a, r);
    count_busy(n);
    check("R9 busy length for 0", n, 1);

    // R10 requests while busy
    op_cycles = 8'd6;
    issue(7'h01, 24'd0, a, r);
    issue(7'h20, 24'd0, a, r);
    issue(7'h02, 24'd0, a, r);
    check("R10 latch clear refused", {30'd0, a, r}, 32'd1);
    check("R10 latch untouched", {31'd0, status[1]}, 32'd1);
    issue(7'h04, 24'h00007C, a, r);
    check("R10 write refused", {30'd0, a, r}, 32'd1);
    check("R10 fields untouched", {8'd0, status}, 32'h000A03);
    wait_idle();

    // R11 collisions
    issue(7'h01, 24'd0, a, r);
    issue(7'h03, 24'd0, a, r);
    check("R11 set+clear refused", {30'd0, a, r}, 32'd1);
    check("R11 latch kept", {31'd0, status[1]}, 32'd1);
    issue(7'h18, 24'd0, a, r);
    check("R11 program+erase refused", {30'd0, a, r}, 32'd1);
    check("R11 no op started", {8'd0, status}, 32'h000A02);

    // R12 power cycle during an operation
    op_cycles = 8'd20;
    issue(7'h08, 24'd0, a, r);
    check("R12 op started", {31'd0, busy}, 32'd1);
    pulse_power();
    check("R12 cleared", {8'd0, status}, 32'h000A00);
    @(negedge clk);
    cmd_v = 7'h01;
    pwr_cycle = 1'b1;
    @(negedge clk);
    check("R12 strobe with power refused", {30'd0, cmd_accept, cmd_reject}, 32'd1);
    cmd_v = 7'd0;
    pwr_cycle = 1'b0;
    op_cycles = 8'd3;

    // R6 lock released by power cycle
    issue(7'h01, 24'd0, a, r);
    issue(7'h04, 24'h000104, a, r);
    wait_idle();
    check("R6 lock set", {8'd0, status}, 32'h000B04);
    issue(7'h01, 24'd0, a, r);
    issue(7'h04, 24'h000000, a, r);
    check("R6 write refused", {30'd0, a, r}, 32'd1);
    check("R3 refusal drops latch", {8'd0, status}, 32'h000B04);
    pulse_power();
    check("R6 power releases", {8'd0, status}, 32'h000A04);
    issue(7'h01, 24'd0, a, r);
    issue(7'h04, 24'h000000, a, r);
    check("R6 write after release", {30'd0, a, r}, 32'd2);
    wait_idle();

    // R7 permanent lock
    issue(7'h01, 24'd0, a, r);
    issue(7'h04, 24'h000188, a, r);
    wait_idle();
    check("R7 lock set", {8'd0, status}, 32'h000B88);
    pulse_power();
    check("R7 survives power", {8'd0, status}, 32'h000B88);
    issue(7'h01, 24'd0, a, r);
    issue(7'h04, 24'h000000, a, r);
    check("R7 write refused", {30'd0, a, r}, 32'd1);
    check("R7 fields kept", {8'd0, status}, 32'h000B88);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule